// File: doc/BRIEF.md
# Two-Word Refresh Watchdog Timer

This block is a watchdog timer reached through a plain 32-bit register port: an address, a write strobe, write data and a combinational read-data return. Software arms it by setting an enable bit together with a 5-bit exponent. From then on a down-counter advances once per cycle in which the watchdog clock enable is high, and it expires after a power-of-two number of those ticks. Software keeps it alive with a refresh of two ordered writes, each carrying a fixed magic word. A refresh that breaks the rules is treated as a fault in its own right.

Four things start a reset pulse of fixed width: expiry, a faulty refresh, a software reset request and an external user reset request. When a pulse starts, the block records the cause in a small status field. That field keeps its value through the pulse, so software can read it after restart. Only the hard reset input clears it. Clearing the enable bit does not stop the counter straight away: the stop takes effect on the next valid refresh.

Top module: `magic_wdt`

## Requirements
- R1: After the hard reset (rst_n low) rst_out is 0, the cause field reads 0, and the configuration reads enable 0 with exponent RESET_DELAY (default 31).
- R2: Register offsets: 0x0 soft reset, 0x4 configuration (bit 31 enable, bits [4:0] exponent, other bits read 0), 0x8 refresh word one (a read returns the cause in bits [2:0] and zeros above), 0xC refresh word two. Offsets 0x0 and 0xC read as 0.
- R3: A configuration write with bit 31 set arms an idle counter with exponent d. The counter then expires on the 2^(d+1)-th cycle with wd_tick high, and cycles with wd_tick low do not count.
- R4: Writing 0xABCD1234 to offset 0x8 and then 0x4321DCBA to offset 0xC is a valid refresh. It reloads the counter to a full 2^(d+1) ticks.
- R5: Each of the following is an incorrect refresh and records cause 2: any other word written to offset 0x8; a write to 0xC that is not directly preceded by a valid word-one write; a wrong word written to 0xC. This applies whether the counter is armed or idle.
- R6: Writing the enable bit as 0 leaves an armed counter running. The counter becomes idle only at the next valid refresh.
- R7: A new exponent written while the counter is armed is used only from the next reload. The count already in progress keeps its original length.
- R8: Writing a word with bit 0 set to offset 0x0 records cause 3. Writing it with bit 0 clear has no effect.
- R9: A high user_rst_req records cause 4. When several causes occur in the same cycle, user (4) wins over soft (3) and refresh fault (2), and those win over expiry (1).
- R10: rst_out goes high the cycle after the event and stays high for exactly RST_W (default 16) cycles. During that time, bus writes, ticks and further requests are ignored.
- R11: The cause field changes only when a pulse starts and survives the pulse. The pulse returns the configuration to its reset values and leaves the counter idle.
- R12: While idle, the counter holds its value and never expires, however many ticks arrive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Hard reset, active low, asynchronous |
| wd_tick | input | 1 | Watchdog clock enable; one tick per high cycle |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| user_rst_req | input | 1 | External user reset request |
| rst_out | output | 1 | Reset pulse output |

## Verification
Register writes take effect at the edge on which the strobe is sampled. A fault write, a soft reset write or a user request therefore shows up as rst_out high and the new cause at the first sample after that edge. The read port is combinational and is sampled a moment after the address is set. Expiry is due on the exact edge of the 2^(d+1)-th tick. The bench sweeps exponents 0 to 4 and checks the output one tick before that edge (low) and one tick after it (high). Inputs are driven on falling edges and outputs are sampled there too, so every expected cycle count follows from the number of rising edges in between. The pulse width is counted falling edge by falling edge, starting at the first high sample.

// File: rtl/magic_wdt_pkg.sv
package magic_wdt_pkg;

   localparam logic [7:0] OFS_SOFT  = 8'h00;
   localparam logic [7:0] OFS_CFG   = 8'h04;
   localparam logic [7:0] OFS_KICK1 = 8'h08;
   localparam logic [7:0] OFS_KICK2 = 8'h0C;

   localparam logic [31:0] KICK1_WORD = 32'hABCD_1234;
   localparam logic [31:0] KICK2_WORD = 32'h4321_DCBA;

   typedef enum logic [2:0] {
      CAUSE_POWER  = 3'd0,
      CAUSE_EXPIRE = 3'd1,
      CAUSE_BADREF = 3'd2,
      CAUSE_SOFT   = 3'd3,
      CAUSE_USER   = 3'd4
   } cause_e;

endpackage

// File: rtl/magic_wdt_regs.sv
module magic_wdt_regs
   import magic_wdt_pkg::*;
#(
   parameter int ADDR_W      = 4,
   parameter int DATA_W      = 32,
   parameter int DELAY_W     = 5,
   parameter int RESET_DELAY = 31
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               frozen,
   input  logic               evt,
   input  logic               bus_wr,
   input  logic [ADDR_W-1:0]  bus_addr,
   input  logic [DATA_W-1:0]  bus_wdata,
   input  logic [2:0]         cause_q,
   output logic [DATA_W-1:0]  bus_rdata,
   output logic               cfg_en,
   output logic [DELAY_W-1:0] cfg_delay,
   output logic               arm_req,
   output logic [DELAY_W-1:0] arm_delay,
   output logic               refresh_ok,
   output logic               bad_tickle,
   output logic               soft_req
);

   localparam int EN_BIT = DATA_W - 1;
   localparam logic [DELAY_W-1:0] DEF_DELAY = DELAY_W'(RESET_DELAY);

   logic hit_soft, hit_cfg, hit_k1, hit_k2;
   logic pending_q;

   always_comb begin
      hit_soft = bus_wr && !frozen && (bus_addr == ADDR_W'(OFS_SOFT));
      hit_cfg  = bus_wr && !frozen && (bus_addr == ADDR_W'(OFS_CFG));
      hit_k1   = bus_wr && !frozen && (bus_addr == ADDR_W'(OFS_KICK1));
      hit_k2   = bus_wr && !frozen && (bus_addr == ADDR_W'(OFS_KICK2));
   end

   assign soft_req   = hit_soft && bus_wdata[0];
   assign refresh_ok = hit_k2 && pending_q && (bus_wdata == KICK2_WORD);
   assign bad_tickle = (hit_k1 && (bus_wdata != KICK1_WORD))
                    || (hit_k2 && !(pending_q && (bus_wdata == KICK2_WORD)));
   assign arm_req    = hit_cfg && bus_wdata[EN_BIT];
   assign arm_delay  = bus_wdata[DELAY_W-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pending_q <= 1'b0;
      end else if (evt) begin
         pending_q <= 1'b0;
      end else if (hit_k1) begin
         pending_q <= (bus_wdata == KICK1_WORD);
      end else if (hit_k2) begin
         pending_q <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_en    <= 1'b0;
         cfg_delay <= DEF_DELAY;
      end else if (evt) begin
         cfg_en    <= 1'b0;
         cfg_delay <= DEF_DELAY;
      end else if (hit_cfg) begin
         cfg_en    <= bus_wdata[EN_BIT];
         cfg_delay <= bus_wdata[DELAY_W-1:0];
      end
   end

   always_comb begin
      bus_rdata = '0;
      if (bus_addr == ADDR_W'(OFS_CFG)) begin
         bus_rdata[EN_BIT]        = cfg_en;
         bus_rdata[DELAY_W-1:0]   = cfg_delay;
      end else if (bus_addr == ADDR_W'(OFS_KICK1)) begin
         bus_rdata[2:0] = cause_q;
      end
   end

endmodule

// File: rtl/magic_wdt_counter.sv
module magic_wdt_counter #(
   parameter int DELAY_W     = 5,
   parameter int RESET_DELAY = 31,
   parameter int CNT_W       = (1 << DELAY_W) + 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               frozen,
   input  logic               evt,
   input  logic               tick,
   input  logic               cfg_en,
   input  logic [DELAY_W-1:0] cfg_delay,
   input  logic               arm_req,
   input  logic [DELAY_W-1:0] arm_delay,
   input  logic               refresh_ok,
   output logic               armed,
   output logic [CNT_W-1:0]   count,
   output logic               expire
);

   localparam logic [DELAY_W-1:0] DEF_DELAY = DELAY_W'(RESET_DELAY);

   function automatic logic [CNT_W-1:0] span(input logic [DELAY_W-1:0] d);
      logic [CNT_W-1:0] r;
      r = '0;
      for (int i = 0; i < CNT_W; i++) begin
         r[i] = (i == int'(d) + 1);
      end
      return r;
   endfunction

   assign expire = armed && tick && !frozen && !refresh_ok
                && (count == CNT_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed <= 1'b0;
         count <= span(DEF_DELAY);
      end else if (evt) begin
         armed <= 1'b0;
         count <= span(DEF_DELAY);
      end else if (!frozen) begin
         if (refresh_ok) begin
            count <= span(cfg_delay);
            armed <= cfg_en;
         end else if (arm_req && !armed) begin
            count <= span(arm_delay);
            armed <= 1'b1;
         end else if (armed && tick) begin
            count <= count - 1'b1;
         end
      end
   end

endmodule

// File: rtl/magic_wdt_rstgen.sv
module magic_wdt_rstgen
   import magic_wdt_pkg::*;
#(
   parameter int RST_W = 16,
   parameter int PW    = $clog2(RST_W + 1)
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       user_req,
   input  logic       soft_req,
   input  logic       bad_tickle,
   input  logic       expire,
   output logic       evt,
   output logic [2:0] cause_q,
   output logic       busy
);

   cause_e pick, cause_r;

   assign evt = !busy && (user_req || soft_req || bad_tickle || expire);

   always_comb begin
      if (user_req)        pick = CAUSE_USER;
      else if (soft_req)   pick = CAUSE_SOFT;
      else if (bad_tickle) pick = CAUSE_BADREF;
      else                 pick = CAUSE_EXPIRE;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   cause_r <= CAUSE_POWER;
      else if (evt) cause_r <= pick;
   end

   assign cause_q = cause_r;

   if (RST_W == 1) begin : g_single
      logic hit_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) hit_q <= 1'b0;
         else        hit_q <= evt;
      end
      assign busy = hit_q;
   end else begin : g_multi
      logic [PW-1:0] left_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)               left_q <= '0;
         else if (evt)             left_q <= PW'(RST_W);
         else if (left_q != '0)    left_q <= left_q - 1'b1;
      end
      assign busy = (left_q != '0);
   end

endmodule

// File: rtl/magic_wdt.sv
module magic_wdt
   import magic_wdt_pkg::*;
#(
   parameter int ADDR_W      = 4,
   parameter int DATA_W      = 32,
   parameter int DELAY_W     = 5,
   parameter int RESET_DELAY = 31,
   parameter int RST_W       = 16,
   parameter int CNT_W       = (1 << DELAY_W) + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wd_tick,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic              user_rst_req,
   output logic              rst_out
);

   if (DATA_W != 32) begin : g_bad_data
      $error("magic_wdt: DATA_W must be 32");
   end
   if (ADDR_W < 4 || ADDR_W > 8) begin : g_bad_addr
      $error("magic_wdt: ADDR_W must lie in 4..8");
   end
   if (DELAY_W < 1 || DELAY_W > 5) begin : g_bad_delay
      $error("magic_wdt: DELAY_W must lie in 1..5");
   end
   if (RESET_DELAY < 0 || RESET_DELAY >= (1 << DELAY_W)) begin : g_bad_def
      $error("magic_wdt: RESET_DELAY out of range");
   end
   if (RST_W < 1) begin : g_bad_rst
      $error("magic_wdt: RST_W must be at least 1");
   end

   logic               evt_w, busy_w;
   logic [2:0]         cause_w;
   logic               cfg_en_w, arm_req_w, refresh_w, bad_w, soft_w, expire_w;
   logic [DELAY_W-1:0] cfg_delay_w, arm_delay_w;
   logic               armed_w;
   logic [CNT_W-1:0]   count_w;

   magic_wdt_regs #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .DELAY_W(DELAY_W),
      .RESET_DELAY(RESET_DELAY)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .frozen(busy_w), .evt(evt_w),
      .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .cause_q(cause_w), .bus_rdata(bus_rdata),
      .cfg_en(cfg_en_w), .cfg_delay(cfg_delay_w),
      .arm_req(arm_req_w), .arm_delay(arm_delay_w),
      .refresh_ok(refresh_w), .bad_tickle(bad_w), .soft_req(soft_w)
   );

   magic_wdt_counter #(
      .DELAY_W(DELAY_W), .RESET_DELAY(RESET_DELAY), .CNT_W(CNT_W)
   ) u_cnt (
      .clk(clk), .rst_n(rst_n), .frozen(busy_w), .evt(evt_w),
      .tick(wd_tick), .cfg_en(cfg_en_w), .cfg_delay(cfg_delay_w),
      .arm_req(arm_req_w), .arm_delay(arm_delay_w),
      .refresh_ok(refresh_w), .armed(armed_w), .count(count_w),
      .expire(expire_w)
   );

   magic_wdt_rstgen #(
      .RST_W(RST_W)
   ) u_rst (
      .clk(clk), .rst_n(rst_n), .user_req(user_rst_req),
      .soft_req(soft_w), .bad_tickle(bad_w), .expire(expire_w),
      .evt(evt_w), .cause_q(cause_w), .busy(busy_w)
   );

   assign rst_out = busy_w;

endmodule

// File: rtl/magic_wdt_chk.sv
module magic_wdt_chk
   import magic_wdt_pkg::*;
#(
   parameter int ADDR_W = 4,
   parameter int RST_W  = 16,
   parameter int CNT_W  = 33
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_wr,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [31:0]       bus_wdata,
   input logic              user_rst_req,
   input logic              rst_out,
   input logic [2:0]        cause,
   input logic              armed,
   input logic [CNT_W-1:0]  count
);

   int hi_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       hi_cnt <= 0;
      else if (rst_out) hi_cnt <= hi_cnt + 1;
      else              hi_cnt <= 0;
   end

   assert_pulse_max_R10: assert property (@(posedge clk) disable iff (!rst_n)
      rst_out |-> hi_cnt < RST_W);

   assert_pulse_full_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(rst_out) |-> hi_cnt == RST_W);

   assert_cause_on_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(cause) |-> $rose(rst_out));

   assert_user_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (user_rst_req && !rst_out) |=> (rst_out && cause == 3'd4));

   assert_soft_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == ADDR_W'(OFS_SOFT) && bus_wdata[0]
       && !rst_out && !user_rst_req) |=> (rst_out && cause == 3'd3));

   assert_bad_word_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == ADDR_W'(OFS_KICK1) && bus_wdata != KICK1_WORD
       && !rst_out && !user_rst_req) |=> (rst_out && cause == 3'd2));

   assert_idle_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (!armed && !bus_wr && !user_rst_req) |=> $stable(count));

   assert_armed_live_R3: assert property (@(posedge clk) disable iff (!rst_n)
      armed |-> count != '0);

endmodule

bind magic_wdt magic_wdt_chk #(
   .ADDR_W(ADDR_W), .RST_W(RST_W), .CNT_W(CNT_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
   .bus_wdata(bus_wdata), .user_rst_req(user_rst_req), .rst_out(rst_out),
   .cause(cause_w), .armed(armed_w), .count(count_w)
);

// File: tb/magic_wdt_tb_top.sv
module magic_wdt_tb_top;

   localparam int ADDR_W = 4;
   localparam int RST_W  = 16;
   localparam logic [31:0] W1 = 32'hABCD_1234;
   localparam logic [31:0] W2 = 32'h4321_DCBA;
   localparam logic [31:0] EN = 32'h8000_0000;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              wd_tick = 1'b0;
   logic              bus_wr = 1'b0;
   logic [ADDR_W-1:0] bus_addr = '0;
   logic [31:0]       bus_wdata = '0;
   logic [31:0]       bus_rdata;
   logic              user_rst_req = 1'b0;
   logic              rst_out;

   int n_chk = 0;
   int n_fail = 0;

   always #10 clk = ~clk;

   magic_wdt dut_i (
      .clk(clk), .rst_n(rst_n), .wd_tick(wd_tick), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .user_rst_req(user_rst_req), .rst_out(rst_out)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [ADDR_W-1:0] a, output logic [31:0] v);
      bus_addr = a;
      #1;
      v = bus_rdata;
   endtask

   task automatic ticks(input int n);
      if (n > 0) begin
         @(negedge clk);
         wd_tick = 1'b1;
         repeat (n) @(negedge clk);
         wd_tick = 1'b0;
      end
   endtask

   task automatic kick();
      wr(4'h8, W1);
      wr(4'hC, W2);
   endtask

   task automatic pulse(input string tag);
      int w;
      w = 0;
      while (rst_out === 1'b1 && w < 100) begin
         w++;
         @(negedge clk);
      end
      check(tag, w, RST_W);
   endtask

   task automatic report();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
   endtask

   initial begin
      #(20 * 150000);
      n_fail++;
      $display("FAIL watchdog: run did not finish");
      report();
      $finish;
   end

   initial begin
      logic [31:0] v;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      check("R1 rst_out", {31'b0, rst_out}, 0);
      rd(4'h8, v); check("R1 cause", v, 0);
      rd(4'h4, v); check("R1 config", v, 32'h1F);

      // R12 idle counter ignores ticks
      ticks(100);
      check("R12 idle no expiry", {31'b0, rst_out}, 0);

      // R2 read map
      wr(4'h4, EN | 32'h2);
      rd(4'h4, v); check("R2 config readback", v, 32'h8000_0002);
      rd(4'h0, v); check("R2 soft reads 0", v, 0);
      rd(4'hC, v); check("R2 word two reads 0", v, 0);
      rd(4'h8, v); check("R2 cause field", v, 0);
      kick();
      wr(4'h4, 32'h2);
      kick();

      // R3 / R10 / R11 exponent sweep
      for (int d = 0; d < 5; d++) begin
         int n;
         n = 1 << (d + 1);
         wr(4'h4, EN | 32'(d));
         ticks(n - 1);
         check($sformatf("R3 d=%0d low before", d), {31'b0, rst_out}, 0);
         ticks(1);
         check($sformatf("R3 d=%0d high at expiry", d), {31'b0, rst_out}, 1);
         rd(4'h8, v); check($sformatf("R3 d=%0d cause", d), v, 1);
         pulse($sformatf("R10 d=%0d width", d));
         rd(4'h4, v); check($sformatf("R11 d=%0d config default", d), v, 32'h1F);
         rd(4'h8, v); check($sformatf("R11 d=%0d cause kept", d), v, 1);
      end

      // R4 refresh reloads
      wr(4'h4, EN | 32'h2);
      ticks(6);
      kick();
      ticks(7);
      check("R4 no expiry after refresh", {31'b0, rst_out}, 0);
      ticks(1);
      check("R4 expiry at full length", {31'b0, rst_out}, 1);
      pulse("R10 width after refresh");

      // R7 new exponent waits for reload
      wr(4'h4, EN | 32'h3);
      wr(4'h4, EN | 32'h1);
      ticks(15);
      check("R7 old length kept", {31'b0, rst_out}, 0);
      ticks(1);
      check("R7 old length expiry", {31'b0, rst_out}, 1);
      pulse("R10 width R7a");
      wr(4'h4, EN | 32'h3);
      wr(4'h4, EN | 32'h1);
      kick();
      ticks(3);
      check("R7 new length low", {31'b0, rst_out}, 0);
      ticks(1);
      check("R7 new length expiry", {31'b0, rst_out}, 1);
      pulse("R10 width R7b");

      // R6 disable without refresh still expires
      wr(4'h4, EN | 32'h1);
      wr(4'h4, 32'h1);
      ticks(4);
      check("R6 disable alone keeps running", {31'b0, rst_out}, 1);
      rd(4'h8, v); check("R6 cause expiry", v, 1);
      pulse("R10 width R6");

      // R6 / R12 disable completed by refresh
      wr(4'h4, EN | 32'h1);
      wr(4'h4, 32'h1);
      kick();
      ticks(200);
      check("R6 stopped after refresh", {31'b0, rst_out}, 0);
      check("R12 idle after stop", {31'b0, rst_out}, 0);

      // R5 incorrect refresh variants
      wr(4'h8, 32'h1234_5678);
      check("R5 wrong word one", {31'b0, rst_out}, 1);
      rd(4'h8, v); check("R5 cause wrong word one", v, 2);
      pulse("R10 width R5a");
      wr(4'hC, W2);
      check("R5 word two alone", {31'b0, rst_out}, 1);
      rd(4'h8, v); check("R5 cause word two alone", v, 2);
      pulse("R10 width R5b");
      wr(4'h8, W1);
      check("R5 good word one no reset", {31'b0, rst_out}, 0);
      wr(4'hC, W1);
      check("R5 wrong word two", {31'b0, rst_out}, 1);
      pulse("R10 width R5c");

      // R8 soft reset
      wr(4'h0, 32'h0);
      check("R8 bit0 clear ignored", {31'b0, rst_out}, 0);
      rd(4'h8, v); check("R8 cause unchanged", v, 2);
      wr(4'h0, 32'h1);
      check("R8 soft reset pulse", {31'b0, rst_out}, 1);
      rd(4'h8, v); check("R8 cause soft", v, 3);
      pulse("R10 width R8");

      // R9 user reset and priorities
      @(negedge clk); user_rst_req = 1'b1;
      @(negedge clk); user_rst_req = 1'b0;
      check("R9 user pulse", {31'b0, rst_out}, 1);
      rd(4'h8, v); check("R9 cause user", v, 4);
      pulse("R10 width R9a");
      @(negedge clk);
      bus_addr = 4'h0; bus_wdata = 32'h1; bus_wr = 1'b1; user_rst_req = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0; user_rst_req = 1'b0;
      rd(4'h8, v); check("R9 user beats soft", v, 4);
      pulse("R10 width R9b");
      wr(4'h4, EN);
      ticks(1);
      @(negedge clk); wd_tick = 1'b1; user_rst_req = 1'b1;
      @(negedge clk); wd_tick = 1'b0; user_rst_req = 1'b0;
      rd(4'h8, v); check("R9 user beats expiry", v, 4);
      pulse("R10 width R9c");

      // R10 writes during the pulse are ignored
      @(negedge clk); user_rst_req = 1'b1;
      @(negedge clk); user_rst_req = 1'b0;
      bus_addr = 4'h0; bus_wdata = 32'h1; bus_wr = 1'b1;
      @(negedge clk); bus_wr = 1'b0;
      begin
         int w;
         w = 1;
         while (rst_out === 1'b1 && w < 100) begin
            w++;
            @(negedge clk);
         end
         check("R10 width with write inside", w, RST_W);
      end
      rd(4'h8, v); check("R10 cause not overwritten", v, 4);
      @(negedge clk);
      check("R10 no second pulse", {31'b0, rst_out}, 0);

      // R1 hard reset clears cause
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      rd(4'h8, v); check("R1 cause cleared by hard reset", v, 0);

      report();
      $finish;
   end

endmodule